// File: doc/BRIEF.md
# Rectangle Fill Engine

The block takes one erase/fill command packet, presented as parallel 32-bit words with a one-cycle `start` strobe, and paints a solid rectangle into a 1280×1024 framebuffer through a synchronous write port. It writes one pixel per clock in row-major order. It also keeps a running dirty bounding box that a display refresh path can use to limit its copy. The packet's vertex words hold packed fixed-point coordinates. The line-width word is subtracted from both vertex words before their fields are taken, and it also adds extra rows below the second vertex.

Control is a four-state machine. `S_IDLE` waits for `start` carrying the fill command and latches the packet (`IDLE→DECODE`); any other command keeps it in `S_IDLE`. `S_DECODE` spends one cycle decoding the rectangle and updating the dirty box. It moves to `S_FILL` when the rectangle holds at least one pixel (`DECODE→FILL`), otherwise to `S_FINISH` (`DECODE→FINISH`). `S_FILL` issues one write per cycle and leaves after the last pixel (`FILL→FINISH`). `S_FINISH` raises `done` for one cycle and returns to idle (`FINISH→IDLE`). Pixel depth is 24-bit or 8-bit, chosen by the `PIX_BITS` parameter.

Top module: `rect_fill_engine`

## Requirements
- R1: A packet is accepted only when `start` is high in idle and `cmd_word` equals 0x00000411. A `start` with any other command, or a `start` while busy, causes no write, no `busy`, no `done` and no change to the dirty box.
- R2: `width_word` is subtracted (modulo 2^32) from both vertex words before decoding. In each vertex, x is bits [29:19] and y is bits [12:3] of the difference.
- R3: With extra = (width_word + 1) >> 2, computed unsigned, rows y through y2 + extra − 1 are filled. Rows at 1024 or above are skipped.
- R4: Columns x up to but not including x2 are filled. When x2 − x (signed) is greater than 1280, x2 becomes 1280. Columns at 1280 or above are never written.
- R5: Writes occur one per cycle in consecutive cycles, row-major, at address row × 1280 + column. The first write is on the second cycle after the accepting edge.
- R6: With `PIX_BITS` = 24, every pixel is 0x000000 when attribute bits [23:16] are 0, 0xC0C0C0 when they are 7, and 0xFFFFFF for any other value.
- R7: With `PIX_BITS` = 8, every pixel is attribute bits [7:0].
- R8: `busy` is high from the cycle after acceptance until `done`. `done` is a one-cycle pulse in the cycle after the last write. For an empty rectangle there are no writes, and `done` comes in the second cycle after acceptance.
- R9: After reset the dirty box is x_lo = 2047, x_hi = 0, y_lo = 1023, y_hi = 0. Each accepted packet lowers x_lo to x and raises x_hi to the clamped x2. When at least one pixel is written, y_lo is lowered to y and y_hi is raised to the last row written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Packet present strobe |
| cmd_word | input | 32 | Command word |
| width_word | input | 32 | Line-width word |
| attr_word | input | 32 | Colour attribute word |
| vtx_a_word | input | 32 | First vertex, packed |
| vtx_b_word | input | 32 | Second vertex, packed |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Pixel write strobe |
| wr_addr | output | 21 | Pixel address, row × 1280 + column |
| wr_data | output | PIX_BITS | Pixel value |
| dirty_x_lo | output | 11 | Dirty box left column |
| dirty_x_hi | output | 11 | Dirty box right bound (exclusive x2) |
| dirty_y_lo | output | 10 | Dirty box top row |
| dirty_y_hi | output | 10 | Dirty box bottom row |

## Verification
Small rectangles with zero line width check the basic scan order and the black mapping. Packets with line widths of 3, 7, 8 and 13 add extra rows. Widths of 8 and above also show whether the offset is subtracted before the fields are taken. A 1400-column span hits the width clamp, a rectangle near column 1280 hits the column cap, and one near row 1023 hits the row cap. Zero-width and inverted spans check that `done` still comes when nothing is written. A wrong command word and a second `start` during a long fill check that such packets are ignored. A second instance built with 8-bit pixels runs in parallel and checks that low-byte path.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
    localparam logic [31:0] CMD_FILL = 32'h0000_0411;
    localparam int XW    = 11;
    localparam int YW    = 10;
    localparam int X_LSB = 19;
    localparam int Y_LSB = 3;
    localparam logic [7:0] GREY_MID = 8'hC0;
    localparam logic [7:0] SEL_MID  = 8'd7;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DECODE,
        S_FILL,
        S_FINISH
    } fill_state_t;
endpackage

// File: rtl/rfe_decode.sv
module rfe_decode
    import rfe_pkg::*;
#(
    parameter int FB_W     = 1280,
    parameter int FB_H     = 1024,
    parameter int PIX_BITS = 24
) (
    input  logic [31:0]         lw,
    input  logic [31:0]         attr,
    input  logic [31:0]         va,
    input  logic [31:0]         vb,
    output logic [XW-1:0]       x_start,
    output logic [XW-1:0]       x2_clamped,
    output logic [XW-1:0]       col_end,
    output logic [YW-1:0]       y_start,
    output logic [YW:0]         row_end,
    output logic [YW-1:0]       y_last,
    output logic                has_pixels,
    output logic [PIX_BITS-1:0] colour
);
    logic [31:0]          a_off, b_off;
    logic [XW-1:0]        x2_raw;
    logic [YW-1:0]        y2_raw;
    logic signed [XW+1:0] span;
    logic [32:0]          lw_inc;
    logic [32:0]          row_sum;
    logic [YW:0]          row_end_m1;

    always_comb begin
        a_off      = va - lw;
        b_off      = vb - lw;
        x_start    = a_off[X_LSB +: XW];
        y_start    = a_off[Y_LSB +: YW];
        x2_raw     = b_off[X_LSB +: XW];
        y2_raw     = b_off[Y_LSB +: YW];

        span       = $signed({2'b00, x2_raw}) - $signed({2'b00, x_start});
        x2_clamped = (span > $signed((XW+2)'(FB_W))) ? XW'(FB_W) : x2_raw;
        col_end    = (x2_clamped > XW'(FB_W)) ? XW'(FB_W) : x2_clamped;

        lw_inc     = {1'b0, lw} + 33'd1;
        row_sum    = {{(33-YW){1'b0}}, y2_raw} + {2'b00, lw_inc[32:2]};
        row_end    = (row_sum > 33'(FB_H)) ? (YW+1)'(FB_H) : row_sum[YW:0];
        row_end_m1 = row_end - (YW+1)'(1);
        y_last     = row_end_m1[YW-1:0];

        has_pixels = (col_end > x_start) && (row_end > {1'b0, y_start});
    end

    generate
        if (PIX_BITS == 24) begin : g_grey24
            always_comb begin
                unique case (attr[23:16])
                    8'd0:    colour = '0;
                    SEL_MID: colour = {3{GREY_MID}};
                    default: colour = '1;
                endcase
            end
        end else begin : g_direct
            assign colour = attr[PIX_BITS-1:0];
        end
    endgenerate
endmodule

// File: rtl/rfe_scan.sv
module rfe_scan
    import rfe_pkg::*;
#(
    parameter int FB_W   = 1280,
    parameter int FB_H   = 1024,
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [XW-1:0]     x_start,
    input  logic [XW-1:0]     col_end,
    input  logic [YW-1:0]     y_start,
    input  logic [YW:0]       row_end,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    logic [XW-1:0] col_q;
    logic [YW-1:0] row_q;
    logic          row_wrap;

    assign row_wrap = (col_q + XW'(1)) == col_end;
    assign last     = row_wrap && (({1'b0, row_q} + (YW+1)'(1)) == row_end);
    assign addr     = ADDR_W'(row_q) * ADDR_W'(FB_W) + ADDR_W'(col_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else if (load) begin
            col_q <= x_start;
            row_q <= y_start;
        end else if (step) begin
            if (row_wrap) begin
                col_q <= x_start;
                row_q <= row_q + YW'(1);
            end else begin
                col_q <= col_q + XW'(1);
            end
        end
    end

    AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (col_q < col_end) && (col_q < XW'(FB_W))); // R4
    AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> ({1'b0, row_q} < row_end) && ({1'b0, row_q} < (YW+1)'(FB_H))); // R3
endmodule

// File: rtl/rfe_dirty.sv
module rfe_dirty
    import rfe_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic          rows_touched,
    input  logic [XW-1:0] x_new,
    input  logic [XW-1:0] x2_new,
    input  logic [YW-1:0] y_new,
    input  logic [YW-1:0] y_last,
    output logic [XW-1:0] x_lo,
    output logic [XW-1:0] x_hi,
    output logic [YW-1:0] y_lo,
    output logic [YW-1:0] y_hi
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_lo <= '1;
            x_hi <= '0;
            y_lo <= '1;
            y_hi <= '0;
        end else if (upd) begin
            if (x_new < x_lo)  x_lo <= x_new;
            if (x2_new > x_hi) x_hi <= x2_new;
            if (rows_touched) begin
                if (y_new < y_lo)  y_lo <= y_new;
                if (y_last > y_hi) y_hi <= y_last;
            end
        end
    end

    AST_BOX_ONLY_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (x_lo <= $past(x_lo)) && (x_hi >= $past(x_hi))
                && (y_lo <= $past(y_lo)) && (y_hi >= $past(y_hi))); // R9
    AST_BOX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(x_lo) && $stable(x_hi) && $stable(y_lo) && $stable(y_hi)); // R9
endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
    import rfe_pkg::*;
#(
    parameter int FB_W     = 1280,
    parameter int FB_H     = 1024,
    parameter int PIX_BITS = 24,
    localparam int ADDR_W  = $clog2(FB_W * FB_H)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [31:0]         cmd_word,
    input  logic [31:0]         width_word,
    input  logic [31:0]         attr_word,
    input  logic [31:0]         vtx_a_word,
    input  logic [31:0]         vtx_b_word,
    output logic                busy,
    output logic                done,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [PIX_BITS-1:0] wr_data,
    output logic [XW-1:0]       dirty_x_lo,
    output logic [XW-1:0]       dirty_x_hi,
    output logic [YW-1:0]       dirty_y_lo,
    output logic [YW-1:0]       dirty_y_hi
);
    fill_state_t state_q, state_d;
    logic [31:0] lw_q, attr_q, va_q, vb_q;
    logic        accept;

    logic [XW-1:0] x_start, x2_clamped, col_end;
    logic [YW-1:0] y_start, y_last;
    logic [YW:0]   row_end;
    logic          has_pixels;
    logic          scan_last;

    assign accept = (state_q == S_IDLE) && start && (cmd_word == CMD_FILL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lw_q   <= '0;
            attr_q <= '0;
            va_q   <= '0;
            vb_q   <= '0;
        end else if (accept) begin
            lw_q   <= width_word;
            attr_q <= attr_word;
            va_q   <= vtx_a_word;
            vb_q   <= vtx_b_word;
        end
    end

    rfe_decode #(.FB_W(FB_W), .FB_H(FB_H), .PIX_BITS(PIX_BITS)) u_decode (
        .lw         (lw_q),
        .attr       (attr_q),
        .va         (va_q),
        .vb         (vb_q),
        .x_start    (x_start),
        .x2_clamped (x2_clamped),
        .col_end    (col_end),
        .y_start    (y_start),
        .row_end    (row_end),
        .y_last     (y_last),
        .has_pixels (has_pixels),
        .colour     (wr_data)
    );

    rfe_scan #(.FB_W(FB_W), .FB_H(FB_H), .ADDR_W(ADDR_W)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state_q == S_DECODE),
        .step    (wr_en),
        .x_start (x_start),
        .col_end (col_end),
        .y_start (y_start),
        .row_end (row_end),
        .addr    (wr_addr),
        .last    (scan_last)
    );

    rfe_dirty u_dirty (
        .clk          (clk),
        .rst_n        (rst_n),
        .upd          (state_q == S_DECODE),
        .rows_touched (has_pixels),
        .x_new        (x_start),
        .x2_new       (x2_clamped),
        .y_new        (y_start),
        .y_last       (y_last),
        .x_lo         (dirty_x_lo),
        .x_hi         (dirty_x_hi),
        .y_lo         (dirty_y_lo),
        .y_hi         (dirty_y_hi)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_d = S_DECODE;
            S_DECODE: state_d = has_pixels ? S_FILL : S_FINISH;
            S_FILL:   if (scan_last) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_comb begin
        busy  = (state_q != S_IDLE);
        wr_en = (state_q == S_FILL);
        done  = (state_q == S_FINISH);
    end

    AST_IGNORE_OTHER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && cmd_word != CMD_FILL) |=> !busy && !wr_en); // R1
    AST_ADDR_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr > $past(wr_addr))); // R5
    AST_ADDR_IN_FB: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr < ADDR_W'(FB_W * FB_H))); // R4
    AST_COLOUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> $stable(wr_data)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy); // R8
endmodule

// File: tb/sim_rect_fill_engine.sv
module sim_rect_fill_engine;
    typedef struct packed {
        logic [31:0] lw;
        logic [31:0] attr;
        logic [10:0] x;
        logic [9:0]  y;
        logic [10:0] x2;
        logic [9:0]  y2;
        logic [31:0] n_exp;
        logic [23:0] col_exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{32'd0,  32'h0000_00AB, 11'd2,    10'd3,    11'd6,    10'd5,    32'd8,    24'h000000},
        '{32'd3,  32'h0007_0000, 11'd10,   10'd1,    11'd13,   10'd2,    32'd6,    24'hC0C0C0},
        '{32'd7,  32'h0005_0000, 11'd0,    10'd0,    11'd1,    10'd1,    32'd3,    24'hFFFFFF},
        '{32'd0,  32'h00FF_0000, 11'd5,    10'd0,    11'd5,    10'd4,    32'd0,    24'hFFFFFF},
        '{32'd3,  32'h0007_0000, 11'd0,    10'd1023, 11'd1400, 10'd1023, 32'd1280, 24'hC0C0C0},
        '{32'd0,  32'h0001_0000, 11'd1270, 10'd4,    11'd1290, 10'd5,    32'd10,   24'hFFFFFF},
        '{32'd8,  32'h0000_0033, 11'd0,    10'd1022, 11'd2,    10'd1023, 32'd4,    24'h000000},
        '{32'd0,  32'h00FF_0000, 11'd100,  10'd0,    11'd50,   10'd9,    32'd0,    24'hFFFFFF},
        '{32'd13, 32'h0007_0000, 11'd3,    10'd2,    11'd5,    10'd3,    32'd8,    24'hC0C0C0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cmd_word = '0, width_word = '0, attr_word = '0;
    logic [31:0] vtx_a_word = '0, vtx_b_word = '0;
    logic        busy, done, wr_en;
    logic [20:0] wr_addr;
    logic [23:0] wr_data;
    logic [10:0] dxl, dxh;
    logic [9:0]  dyl, dyh;
    logic        busy8, done8, wr_en8;
    logic [20:0] wr_addr8;
    logic [7:0]  wr_data8;
    logic [10:0] dxl8, dxh8;
    logic [9:0]  dyl8, dyh8;

    int n_chk = 0;
    int n_bad = 0;
    int m_xl = 2047, m_xh = 0, m_yl = 1023, m_yh = 0;

    always #2 clk = ~clk;

    rect_fill_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_word(cmd_word),
        .width_word(width_word), .attr_word(attr_word),
        .vtx_a_word(vtx_a_word), .vtx_b_word(vtx_b_word),
        .busy(busy), .done(done), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dirty_x_lo(dxl), .dirty_x_hi(dxh),
        .dirty_y_lo(dyl), .dirty_y_hi(dyh)
    );

    rect_fill_engine #(.PIX_BITS(8)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_word(cmd_word),
        .width_word(width_word), .attr_word(attr_word),
        .vtx_a_word(vtx_a_word), .vtx_b_word(vtx_b_word),
        .busy(busy8), .done(done8), .wr_en(wr_en8), .wr_addr(wr_addr8),
        .wr_data(wr_data8), .dirty_x_lo(dxl8), .dirty_x_hi(dxh8),
        .dirty_y_lo(dyl8), .dirty_y_hi(dyh8)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_box(input string req);
        check(dxl == 11'(m_xl), {req, " dirty x_lo"}, dxl, m_xl);
        check(dxh == 11'(m_xh), {req, " dirty x_hi"}, dxh, m_xh);
        check(dyl == 10'(m_yl), {req, " dirty y_lo"}, dyl, m_yl);
        check(dyh == 10'(m_yh), {req, " dirty y_hi"}, dyh, m_yh);
    endtask

    function automatic logic [31:0] pack_v(input int x, input int y, input logic [31:0] lw);
        return ((32'(x) << 19) | (32'(y) << 3)) + lw;
    endfunction

    task automatic run_case(input vec_t e, input bit poke_mid);
        int x, y, x2c, cend, rend, r, c, n, bad_addr, bad_d24, bad_d8, done_at, k;
        longint extra;
        bit fin;
        x = int'(e.x); y = int'(e.y);
        x2c = (int'(e.x2) - x > 1280) ? 1280 : int'(e.x2);          // R4
        cend = (x2c > 1280) ? 1280 : x2c;
        extra = (longint'(e.lw) + 1) >>> 2;                          // R3
        rend = (longint'(e.y2) + extra > 1024) ? 1024 : int'(longint'(e.y2) + extra);
        r = y; c = x; n = 0; bad_addr = 0; bad_d24 = 0; bad_d8 = 0; done_at = -1; fin = 0;

        @(negedge clk);
        cmd_word = 32'h411; width_word = e.lw; attr_word = e.attr;
        vtx_a_word = pack_v(x, y, e.lw);                             // R2
        vtx_b_word = pack_v(int'(e.x2), int'(e.y2), e.lw);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !wr_en, "R8 busy after accept", busy, 1);
        for (k = 2; k < 3000 && !fin; k++) begin
            @(negedge clk);
            if (poke_mid && k == 100) begin
                vtx_a_word = pack_v(0, 0, 0); vtx_b_word = pack_v(5, 5, 0);
                start = 1'b1;                                        // R1 start while busy
            end else begin
                start = 1'b0;
            end
            if (wr_en) begin
                if (n == 0) check(k == 2, "R5 first write cycle", k, 2);
                if (wr_addr != 21'(r * 1280 + c)) bad_addr++;
                if (wr_data != e.col_exp) bad_d24++;
                if (!wr_en8 || wr_data8 != e.attr[7:0]) bad_d8++;
                n++; c++;
                if (c == cend) begin c = x; r++; end
            end
            if (done) begin done_at = k; fin = 1; end
        end
        start = 1'b0;
        check(n == int'(e.n_exp), "R3 R4 write count", n, e.n_exp);
        check(bad_addr == 0, "R5 row-major addresses", bad_addr, 0);
        check(bad_d24 == 0, "R6 grey colour mapping", bad_d24, 0);
        check(bad_d8 == 0, "R7 low-byte colour", bad_d8, 0);
        check(done_at == 2 + n, "R8 done timing", done_at, 2 + n);
        if (x < m_xl) m_xl = x;                                      // R9
        if (x2c > m_xh) m_xh = x2c;
        if (n > 0) begin
            if (y < m_yl) m_yl = y;
            if (rend - 1 > m_yh) m_yh = rend - 1;
        end
        check_box("R9");
        @(negedge clk);
        check(!done && !busy, "R8 done single cycle", done, 0);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !wr_en, "R8 reset idle", busy, 0);
        check_box("R9 reset");

        for (int i = 0; i < NV; i++) run_case(TBL[i], i == 4);

        // R1: other command word ignored
        @(negedge clk);
        cmd_word = 32'h405; width_word = 0; attr_word = 0;
        vtx_a_word = pack_v(1, 1, 0); vtx_b_word = pack_v(900, 600, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < 20; k++) begin
                if (busy || wr_en || done) seen++;
                @(negedge clk);
            end
            check(seen == 0, "R1 foreign command ignored", seen, 0);
        end
        check_box("R1 dirty untouched");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule